// File: doc/BRIEF.md
# SCSI Message-Out Byte Parser

This block decodes the bytes an initiator sends to a target during the message-out phase of a SCSI bus transaction. A controller loads a byte count and a base tag with a start pulse. It then offers one byte per cycle. The parser takes each offered byte while it is busy and lowers the remaining count by one. It stops when the count reaches zero, when it rejects a message, or when the count runs out in the middle of a message.

The parser recognises three kinds of message:

- **Single-byte messages.** Disconnect, no-operation and IDENTIFY.
- **Extended messages.** The parser consumes and discards synchronous and wide negotiation messages. It does not negotiate anything.
- **Two-byte queue-tag messages.** The tag byte is merged into the current tag.

The parser holds these results until the next start:

- the last requested phase change
- the selected logical unit
- the composite tag
- a rejection request, with the reply byte to send back
- the last byte seen
- a flag for the unsupported queue types
- a flag for a message that ends early

Top module: `msgout_parser`

## Requirements
- R1: A start pulse given while the parser is idle loads `remaining` from `start_count`. The parser then takes one byte on every cycle where `in_ready` and `in_valid` are both high, and `remaining` drops by one each time. `in_ready` falls once `remaining` reaches zero. A start with a count of zero consumes nothing.
- R2: Every consumed byte, including length bytes, code bytes, skipped bytes and tag bytes, appears on `last_byte` after its clock edge.
- R3: Two single-byte messages set `phase_req`, and parsing continues afterwards, so the last request wins:
  - Byte 0x00 sets `phase_req` to 3 (disconnect).
  - Byte 0x08 sets `phase_req` to 1 (command).
- R4: Byte 0x01 opens an extended message made of a length byte followed by a code byte. Code 0x01 discards the next two bytes and code 0x03 discards the next one. Neither changes `phase_req`, `lun` or `tag`.
- R5: An extended message whose code is neither 0x01 nor 0x03 is rejected in the same way as R9.
- R6: Bytes 0x20, 0x21 and 0x22 each take one following tag byte. That byte is ORed into `tag[7:0]` and `tag[16]` is set. A start loads `tag` with bit 16 clear and bits 15:0 from `tag_base`.
- R7: Bytes 0x21 and 0x22 also set `qtype_warn`. Byte 0x20 does not.
- R8: Any byte with bit 7 set, taken where a message starts, sets `lun` to bits 2:0 of that byte and sets `phase_req` to 1. `lun` keeps its value across starts.
- R9: Any other byte taken where a message starts, with bit 7 clear, is a rejection:
  - `reject` is set, `phase_req` becomes 2 (message in) and `reply_byte` becomes 0x07.
  - Parsing stops at once, and the bytes still counted stay unconsumed in `remaining`.
- R10: If `remaining` reaches zero inside an extended or queue-tag message, `underrun` is set and parsing stops. `underrun` and `reject` are never both set.
- R11: After reset, and again after each start, the parser clears `phase_req`, `reject`, `reply_byte`, `qtype_warn` and `underrun`. Reset also clears `lun`, `tag`, `last_byte` and `remaining`, and leaves the parser idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a parse; ignored while busy |
| start_count | input | CNT_W | Number of bytes in the message-out transfer |
| tag_base | input | 16 | Tag value loaded at start (target id in bits 11:8) |
| in_valid | input | 1 | A message byte is offered |
| in_byte | input | 8 | Offered message byte |
| in_ready | output | 1 | High while the parser accepts bytes |
| remaining | output | CNT_W | Bytes still to be consumed |
| phase_req | output | 2 | 0 none, 1 command, 2 message in, 3 disconnect |
| lun | output | 3 | Selected logical unit |
| tag | output | 17 | Composite tag; bit 16 means the tag is valid |
| reject | output | 1 | A MESSAGE REJECT reply is requested |
| reply_byte | output | 8 | Byte queued for the message-in phase |
| last_byte | output | 8 | Last consumed byte |
| qtype_warn | output | 1 | A head-of-queue or ordered tag was received |
| underrun | output | 1 | The count ran out inside a message |

## Verification
The bench builds the parser with the default `CNT_W` of 8, which is wide enough for every multi-byte sequence it drives. With that width, all 256 byte values can be swept as one-byte transfers, and each result is predicted from the byte's value alone. A second sweep sends a 0x20 message followed by every possible tag byte, against a fixed base tag. Directed sequences then cover the remaining cases:

- skipping of the negotiation messages
- a rejection that leaves bytes unconsumed
- an underrun inside a skip
- a start with a count of zero
- a last-request-wins ordering

// File: rtl/msgout_parser.sv
module msgout_parser #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_count,
  input  logic [15:0]      tag_base,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic [CNT_W-1:0] remaining,
  output logic [1:0]       phase_req,
  output logic [2:0]       lun,
  output logic [16:0]      tag,
  output logic             reject,
  output logic [7:0]       reply_byte,
  output logic [7:0]       last_byte,
  output logic             qtype_warn,
  output logic             underrun
);
  localparam logic [2:0] S_IDLE = 3'd0, S_OPC = 3'd1, S_XLEN = 3'd2,
                         S_XCODE = 3'd3, S_SKIP = 3'd4, S_TAG = 3'd5;
  localparam logic [1:0] PH_NONE = 2'd0, PH_CMD = 2'd1, PH_MSGIN = 2'd2, PH_DISC = 2'd3;

  logic [2:0] state, nxt;
  logic [1:0] skip, skip_nxt;
  logic       rej_now;
  logic       take;

  assign in_ready = (state != S_IDLE);
  assign take     = in_ready && in_valid;

  always_comb begin
    nxt      = S_OPC;
    rej_now  = 1'b0;
    skip_nxt = skip;
    case (state)
      S_OPC: begin
        if (in_byte == 8'h01) nxt = S_XLEN;
        else if (in_byte == 8'h20 || in_byte == 8'h21 || in_byte == 8'h22) nxt = S_TAG;
        else if (in_byte != 8'h00 && in_byte != 8'h08 && !in_byte[7]) rej_now = 1'b1;
      end
      S_XLEN: nxt = S_XCODE;
      S_XCODE: begin
        if (in_byte == 8'h01)      begin nxt = S_SKIP; skip_nxt = 2'd2; end
        else if (in_byte == 8'h03) begin nxt = S_SKIP; skip_nxt = 2'd1; end
        else rej_now = 1'b1;
      end
      S_SKIP: begin
        skip_nxt = skip - 2'd1;
        nxt = (skip == 2'd1) ? S_OPC : S_SKIP;
      end
      default: nxt = S_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  skip <= '0;     remaining <= '0;
      phase_req <= PH_NONE; lun <= '0;  tag <= '0;
      reject <= 1'b0;   reply_byte <= '0; last_byte <= '0;
      qtype_warn <= 1'b0; underrun <= 1'b0;
    end else if (start && state == S_IDLE) begin
      remaining <= start_count;
      phase_req <= PH_NONE;
      tag <= {1'b0, tag_base};
      reject <= 1'b0;  reply_byte <= '0;
      qtype_warn <= 1'b0; underrun <= 1'b0;
      skip <= '0;
      state <= (start_count != '0) ? S_OPC : S_IDLE;
    end else if (take) begin
      remaining <= remaining - 1'b1;
      last_byte <= in_byte;
      skip <= skip_nxt;
      if (state == S_OPC) begin
        case (in_byte)
          8'h00: phase_req <= PH_DISC;
          8'h08: phase_req <= PH_CMD;
          8'h21, 8'h22: qtype_warn <= 1'b1;
          default: if (in_byte[7]) begin
            lun <= in_byte[2:0];
            phase_req <= PH_CMD;
          end
        endcase
      end
      if (state == S_TAG) tag <= {1'b1, tag[15:8], tag[7:0] | in_byte};
      if (rej_now) begin
        reject <= 1'b1;
        reply_byte <= 8'h07;
        phase_req <= PH_MSGIN;
        state <= S_IDLE;
      end else if (remaining == 1) begin
        underrun <= (nxt != S_OPC);
        state <= S_IDLE;
      end else begin
        state <= nxt;
      end
    end
  end
endmodule

// File: rtl/msgout_parser_chk.sv
module msgout_parser_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       in_byte,
  input logic             in_ready,
  input logic [CNT_W-1:0] remaining,
  input logic [1:0]       phase_req,
  input logic [16:0]      tag,
  input logic             reject,
  input logic [7:0]       reply_byte,
  input logic [7:0]       last_byte,
  input logic             underrun
);
  AST_BUSY_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> remaining != '0); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> remaining == $past(remaining) - 1'b1); // R1
  AST_LAST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid) |=> last_byte == $past(in_byte)); // R2
  AST_TAG_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (tag & $past(tag)) == $past(tag)); // R6
  AST_REJECT_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (phase_req == 2'd2 && reply_byte == 8'h07 && !in_ready)); // R9
  AST_NO_BOTH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(reject && underrun)); // R10
  AST_UNDERRUN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (!in_ready && remaining == '0)); // R10
endmodule

bind msgout_parser msgout_parser_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
  .in_ready(in_ready), .remaining(remaining), .phase_req(phase_req),
  .tag(tag), .reject(reject), .reply_byte(reply_byte),
  .last_byte(last_byte), .underrun(underrun));

// File: tb/msgout_parser_tb_top.sv
`timescale 1ns/1ps
module msgout_parser_tb_top;
  localparam int CNT_W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] start_count = '0;
  logic [15:0] tag_base = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready;
  logic [CNT_W-1:0] remaining;
  logic [1:0] phase_req;
  logic [2:0] lun;
  logic [16:0] tag;
  logic reject, qtype_warn, underrun;
  logic [7:0] reply_byte, last_byte;

  int checks = 0;
  int errors = 0;
  int taken;
  logic [7:0] msg [0:7];

  always #2.5 clk = ~clk;

  msgout_parser #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_count(start_count),
    .tag_base(tag_base), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .remaining(remaining), .phase_req(phase_req),
    .lun(lun), .tag(tag), .reject(reject), .reply_byte(reply_byte),
    .last_byte(last_byte), .qtype_warn(qtype_warn), .underrun(underrun));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input int cnt, input int n, input logic [15:0] base);
    @(negedge clk);
    start = 1'b1; start_count = cnt[CNT_W-1:0]; tag_base = base; in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    taken = 0;
    while (in_ready && taken < 64) begin
      in_valid = 1'b1;
      in_byte = (taken < n) ? msg[taken] : 8'h00;
      @(negedge clk);
      taken++;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(phase_req == 0 && lun == 0 && tag == 0 && !reject && !underrun && !qtype_warn
        && !in_ready && remaining == 0 && last_byte == 0, "R11 reset", {phase_req, lun}, 0);
    rst_n = 1'b1;

    // R1: a start with a zero count consumes nothing
    msg[0] = 8'h08;
    run(0, 1, 16'h0000);
    chk(taken == 0, "R1 zero count", taken, 0);
    chk(phase_req == 0, "R1 zero count phase", phase_req, 0);

    // one-byte sweep over every value
    for (int b = 0; b < 256; b++) begin
      logic [1:0] ep;
      logic er, eu, ew;
      logic [2:0] el;
      el = lun;
      er = 0; eu = 0; ew = 0; ep = 0;
      if (b == 8'h00) ep = 3;
      else if (b == 8'h08) ep = 1;
      else if (b == 8'h01 || b == 8'h20) eu = 1;
      else if (b == 8'h21 || b == 8'h22) begin eu = 1; ew = 1; end
      else if (b >= 8'h80) begin ep = 1; el = b[2:0]; end
      else begin er = 1; ep = 2; end
      msg[0] = b[7:0];
      run(1, 1, 16'h0500);
      chk(taken == 1 && remaining == 0, "R1 single byte consumed", taken, 1);
      chk(last_byte == b[7:0], "R2 last byte", last_byte, b);
      chk(phase_req == ep, "R3 R8 R9 phase", phase_req, ep);
      chk(lun == el, "R8 lun", lun, el);
      chk(reject == er && reply_byte == (er ? 8'h07 : 8'h00), "R9 reject", {reject, reply_byte}, {er, er ? 8'h07 : 8'h00});
      chk(underrun == eu, "R10 underrun", underrun, eu);
      chk(qtype_warn == ew, "R7 warn", qtype_warn, ew);
      chk(tag == 17'h00500, "R6 tag untouched", tag, 17'h00500);
    end

    // R6: simple tag sweep
    for (int t = 0; t < 256; t++) begin
      msg[0] = 8'h20; msg[1] = t[7:0];
      run(2, 2, 16'h0310);
      chk(tag == (17'h10310 | t), "R6 tag merge", tag, 17'h10310 | t);
      chk(!qtype_warn && !underrun && !reject && last_byte == t[7:0], "R7 simple no warn", qtype_warn, 0);
    end

    // R7: ordered tag
    msg[0] = 8'h22; msg[1] = 8'h41;
    run(2, 2, 16'h0200);
    chk(qtype_warn && tag == 17'h10241, "R7 ordered tag", tag, 17'h10241);

    // R3: last request wins
    msg[0] = 8'h08; msg[1] = 8'h00;
    run(2, 2, 16'h0);
    chk(phase_req == 3, "R3 disconnect after nop", phase_req, 3);
    msg[0] = 8'h00; msg[1] = 8'h08;
    run(2, 2, 16'h0);
    chk(phase_req == 1, "R3 nop after disconnect", phase_req, 1);

    // R4: synchronous negotiation skipped, then identify
    msg[0] = 8'h01; msg[1] = 8'h03; msg[2] = 8'h01; msg[3] = 8'h00; msg[4] = 8'h21; msg[5] = 8'hC2;
    run(6, 6, 16'h0);
    chk(taken == 6 && lun == 2 && phase_req == 1 && !reject && !qtype_warn, "R4 sync skip", {lun, phase_req}, {3'd2, 2'd1});
    // R4: wide negotiation skipped, then disconnect
    msg[0] = 8'h01; msg[1] = 8'h02; msg[2] = 8'h03; msg[3] = 8'h08; msg[4] = 8'h00;
    run(5, 5, 16'h0);
    chk(taken == 5 && phase_req == 3 && lun == 2 && !reject, "R4 wide skip", phase_req, 3);
    chk(last_byte == 8'h00, "R2 last after wide", last_byte, 0);
    // R4: skip only, no phase change
    msg[0] = 8'h01; msg[1] = 8'h03; msg[2] = 8'h01; msg[3] = 8'h80; msg[4] = 8'h08;
    run(5, 5, 16'h0);
    chk(phase_req == 0 && lun == 2 && last_byte == 8'h08 && !underrun, "R4 skip no effect", phase_req, 0);

    // R5: unknown extended code
    msg[0] = 8'h01; msg[1] = 8'h02; msg[2] = 8'h05; msg[3] = 8'h08;
    run(4, 4, 16'h0);
    chk(reject && phase_req == 2 && reply_byte == 8'h07 && remaining == 1 && taken == 3, "R5 bad extended", remaining, 1);

    // R9: reject stops with bytes left
    msg[0] = 8'h83; msg[1] = 8'h05; msg[2] = 8'h08;
    run(3, 3, 16'h0);
    chk(taken == 2 && remaining == 1 && !in_ready, "R9 stops early", remaining, 1);
    chk(lun == 3 && phase_req == 2 && last_byte == 8'h05, "R9 phase msg in", phase_req, 2);

    // R10: underrun inside skip
    msg[0] = 8'h01; msg[1] = 8'h03; msg[2] = 8'h01; msg[3] = 8'h00;
    run(4, 4, 16'h0);
    chk(underrun && !reject && remaining == 0 && taken == 4, "R10 underrun in skip", underrun, 1);

    // R11: start clears flags
    msg[0] = 8'h80;
    run(1, 1, 16'h0);
    chk(!underrun && !reject && reply_byte == 0 && lun == 0 && phase_req == 1, "R11 start clears", {underrun, reject}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule